// File: doc/BRIEF.md
# Sideband Virtual-Wire Warning Responder

This block is the slave-side handshake engine for sideband virtual wires on a serial host link. The link layer decodes incoming wire messages into a level and a one-cycle change flag per wire. The block watches three warning wires from the host: suspend warning, host-reset warning and out-of-band-reset warning. When a warning is reported asserted, it raises the matching acknowledge wire without any firmware involvement, so the host never stalls waiting for an answer.

The block also drives the boot-load-done and boot-load-status wires, which it sets together once after its own reset. A full power-off entry clears them. When the link reports a hardware reset, the block pulses its controller reset output low for a fixed number of cycles. It then replays boot-done/status and any suspend acknowledge that is still owed. The platform-reset wire is tracked as a three-valued state that starts unknown, with a strobe on every reported change.

Every change on an outgoing wire raises an update request toward the link layer. The request is held until the link layer accepts it.

Top module: `vw_warn_responder`

## Requirements
- R1: While and right after reset, all acknowledges, boot-load-done, boot-load-status, plat_evt and upd_req are 0, ctrl_rst_n is 1, and plat_state is unknown (2'b10).
- R2: At the first clock edge after reset is released, boot_done and boot_status both become 1.
- R3: Wire indices are bit 0 suspend warning, bit 1 host-reset warning, bit 2 out-of-band-reset warning and bit 3 platform reset. ack_out bit i becomes 1 at the edge where wire_chg[i], wire_lvl[i] and enable are all high.
- R4: A change flag with a low level (a deasserting report), or a high level with no change flag, sets no acknowledge.
- R5: While enable is low, no acknowledge is set, neither from a warning report nor from a hardware-reset replay.
- R6: Once set, an acknowledge stays 1 until block reset.
- R7: g3_entry clears boot_done and boot_status together. They stay 0 until a hardware-reset replay, and nothing else clears them.
- R8: A link_hwrst pulse seen while idle drives ctrl_rst_n low for RST_LOW_CYC cycles starting at the next edge. A link_hwrst pulse during that sequence is ignored.
- R9: One edge after ctrl_rst_n returns high, the replay sets boot_done/boot_status. It also sets the suspend acknowledge if the suspend level is high and enable is high.
- R10: plat_state encodes low as 2'b00 and high as 2'b01. It takes wire_lvl[3] when wire_chg[3] is high, or when it is still unknown and any change flag is high. plat_evt is high for one cycle after each update that alters plat_state.
- R11: upd_req rises at the edge after any of ack_out, boot_done or boot_status changes. It stays high until an edge where upd_ack is high and no further change is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows automatic acknowledges |
| wire_lvl | input | 4 | Decoded incoming wire levels |
| wire_chg | input | 4 | One-cycle change flags per incoming wire |
| link_hwrst | input | 1 | Link hardware-reset event pulse |
| g3_entry | input | 1 | Full power-off entry pulse |
| upd_ack | input | 1 | Link layer accepts the update request |
| ack_out | output | 3 | Acknowledge wires, same indices as the warnings |
| boot_done | output | 1 | Boot-load-done wire |
| boot_status | output | 1 | Boot-load-status wire (1 = image loaded and intact) |
| ctrl_rst_n | output | 1 | Controller reset field, active low |
| plat_state | output | 2 | Platform-reset state: 00 low, 01 high, 10 unknown |
| plat_evt | output | 1 | Strobe on each platform-reset state change |
| upd_req | output | 1 | Outgoing wire update request |

## Verification
The assertions assume that the link layer asserts upd_ack only as a reply to a pending request. The stimulus never raises it before upd_req is seen high, and lowers it right after one accepting edge. They also assume that link_hwrst and wire_chg are single-cycle pulses. The stimulus drives each pulse for exactly one clock, changing it only on the falling edge. Apart from the one deliberate retrigger during a reset pulse, link_hwrst is raised only when the sequencer is idle.

// File: rtl/vw_resp_pkg.sv
package vw_resp_pkg;

    localparam int NUM_WARN = 3;
    localparam int NUM_IN   = 4;
    localparam int IDX_SUS  = 0;
    localparam int IDX_HRST = 1;
    localparam int IDX_OOB  = 2;
    localparam int IDX_PLT  = 3;
    localparam int OUT_W    = NUM_WARN + 2;

    typedef enum logic [1:0] {
        PLT_LOW     = 2'b00,
        PLT_HIGH    = 2'b01,
        PLT_UNKNOWN = 2'b10
    } plt_state_e;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'b00,
        HS_LOW    = 2'b01,
        HS_REPLAY = 2'b10
    } hw_state_e;

    typedef struct packed {
        logic [NUM_WARN-1:0] ack;
        logic                boot_done;
        logic                boot_status;
    } vw_out_t;

    function automatic plt_state_e plt_encode(input logic lvl);
        return lvl ? PLT_HIGH : PLT_LOW;
    endfunction

endpackage

// File: rtl/vw_ack_unit.sv
module vw_ack_unit (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic lvl,
    input  logic chg,
    input  logic replay,
    output logic ack
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else if (enable && lvl && (chg || replay)) begin
            ack_q <= 1'b1;
        end
    end

    assign ack = ack_q;
endmodule

// File: rtl/vw_hwrst_seq.sv
module vw_hwrst_seq
    import vw_resp_pkg::*;
#(
    parameter int RST_LOW_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hwrst_evt,
    input  logic g3_entry,
    output logic ctrl_rst_n,
    output logic replay,
    output logic boot_done,
    output logic boot_status
);
    localparam int CNT_W = (RST_LOW_CYC > 1) ? $clog2(RST_LOW_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_LOW_CYC - 1);

    hw_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rst_n_q;
    logic             init_q;
    logic             done_q;
    logic             stat_q;
    logic             boot_set;

    assign replay   = (state_q == HS_REPLAY);
    assign boot_set = (init_q || replay) && !stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            rst_n_q <= 1'b1;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (hwrst_evt) begin
                        rst_n_q <= 1'b0;
                        cnt_q   <= CNT_LOAD;
                        state_q <= HS_LOW;
                    end
                end
                HS_LOW: begin
                    if (cnt_q == '0) begin
                        rst_n_q <= 1'b1;
                        state_q <= HS_REPLAY;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= 1'b1;
            done_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            init_q <= 1'b0;
            if (g3_entry) begin
                done_q <= 1'b0;
                stat_q <= 1'b0;
            end else if (boot_set) begin
                done_q <= 1'b1;
                stat_q <= 1'b1;
            end
        end
    end

    assign ctrl_rst_n  = rst_n_q;
    assign boot_done   = done_q;
    assign boot_status = stat_q;
endmodule

// File: rtl/vw_plat_track.sv
module vw_plat_track
    import vw_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  logic       chg_own,
    input  logic       chg_any,
    output logic [1:0] state,
    output logic       evt
);
    plt_state_e state_q;
    plt_state_e state_nx;
    logic       take;
    logic       evt_q;

    assign take     = chg_own || ((state_q == PLT_UNKNOWN) && chg_any);
    assign state_nx = take ? plt_encode(lvl) : state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PLT_UNKNOWN;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            evt_q   <= take && (state_nx != state_q);
        end
    end

    assign state = state_q;
    assign evt   = evt_q;
endmodule

// File: rtl/vw_upd_ctrl.sv
module vw_upd_ctrl #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic         accept,
    output logic         req
);
    logic [W-1:0] shadow_q;
    logic         pend_q;
    logic         diff;

    assign diff = (cur != shadow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            shadow_q <= cur;
            pend_q   <= (pend_q && !accept) || diff;
        end
    end

    assign req = pend_q;
endmodule

// File: rtl/vw_warn_responder.sv
module vw_warn_responder
    import vw_resp_pkg::*;
#(
    parameter int RST_LOW_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [NUM_IN-1:0]   wire_lvl,
    input  logic [NUM_IN-1:0]   wire_chg,
    input  logic                link_hwrst,
    input  logic                g3_entry,
    input  logic                upd_ack,
    output logic [NUM_WARN-1:0] ack_out,
    output logic                boot_done,
    output logic                boot_status,
    output logic                ctrl_rst_n,
    output logic [1:0]          plat_state,
    output logic                plat_evt,
    output logic                upd_req
);
    logic    replay;
    vw_out_t out_vec;

    vw_hwrst_seq #(.RST_LOW_CYC(RST_LOW_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .hwrst_evt  (link_hwrst),
        .g3_entry   (g3_entry),
        .ctrl_rst_n (ctrl_rst_n),
        .replay     (replay),
        .boot_done  (boot_done),
        .boot_status(boot_status)
    );

    for (genvar i = 0; i < NUM_WARN; i++) begin : g_ack
        logic rep_i;
        if (i == IDX_SUS) begin : g_rep
            assign rep_i = replay;
        end else begin : g_norep
            assign rep_i = 1'b0;
        end
        vw_ack_unit u_ack (
            .clk   (clk),
            .rst   (rst),
            .enable(enable),
            .lvl   (wire_lvl[i]),
            .chg   (wire_chg[i]),
            .replay(rep_i),
            .ack   (ack_out[i])
        );
    end

    vw_plat_track u_plat (
        .clk    (clk),
        .rst    (rst),
        .lvl    (wire_lvl[IDX_PLT]),
        .chg_own(wire_chg[IDX_PLT]),
        .chg_any(|wire_chg),
        .state  (plat_state),
        .evt    (plat_evt)
    );

    assign out_vec.ack         = ack_out;
    assign out_vec.boot_done   = boot_done;
    assign out_vec.boot_status = boot_status;

    vw_upd_ctrl #(.W(OUT_W)) u_upd (
        .clk   (clk),
        .rst   (rst),
        .cur   (out_vec),
        .accept(upd_ack),
        .req   (upd_req)
    );
endmodule

// File: rtl/vw_warn_responder_chk.sv
module vw_warn_responder_chk
    import vw_resp_pkg::*;
#(
    parameter int RST_LOW_CYC = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic                link_hwrst,
    input logic                upd_ack,
    input logic [NUM_WARN-1:0] ack_out,
    input logic                boot_done,
    input logic                boot_status,
    input logic                ctrl_rst_n,
    input logic [1:0]          plat_state,
    input logic                plat_evt,
    input logic                upd_req
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ack_out == '0 && !boot_done && !boot_status && ctrl_rst_n
                 && plat_state == 2'b10 && !plat_evt && !upd_req));

    p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ack_out == $past(ack_out)));

    p_ack_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ack_out & $past(ack_out)) == $past(ack_out)));

    p_boot_pair_r7: assert property (@(posedge clk) disable iff (rst)
        boot_done == boot_status);

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_rst_n) |-> $past(link_hwrst));

    p_plat_code_r10: assert property (@(posedge clk) disable iff (rst)
        plat_state != 2'b11);

    p_plat_evt_r10: assert property (@(posedge clk) disable iff (rst)
        plat_evt |-> (plat_state != $past(plat_state)));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (upd_req && !upd_ack) |=> upd_req);
endmodule

bind vw_warn_responder vw_warn_responder_chk #(.RST_LOW_CYC(RST_LOW_CYC)) u_chk (.*);

// File: tb/vw_warn_responder_bench.sv
module vw_warn_responder_bench;
    localparam int LOW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic [3:0] wire_lvl = '0;
    logic [3:0] wire_chg = '0;
    logic       link_hwrst = 1'b0;
    logic       g3_entry = 1'b0;
    logic       upd_ack = 1'b0;
    logic [2:0] ack_out;
    logic       boot_done;
    logic       boot_status;
    logic       ctrl_rst_n;
    logic [1:0] plat_state;
    logic       plat_evt;
    logic       upd_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vw_warn_responder #(.RST_LOW_CYC(LOW)) u_vw_warn_responder (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; enable = 1'b1; wire_lvl = '0; wire_chg = '0;
        link_hwrst = 1'b0; g3_entry = 1'b0; upd_ack = 1'b0;
        tick(); tick();
        rst = 1'b0;
        chk("R1 ack", ack_out, 0);
        chk("R1 boot", {boot_done, boot_status}, 0);
        chk("R1 ctrl_rst_n", ctrl_rst_n, 1);
        chk("R1 plat", plat_state, 2);
        chk("R1 upd", upd_req, 0);
    endtask

    initial begin
        tick();
        // Sweep: each warning x {enable, level, change}
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 8; p++) begin
                int en, lv, cg, exp_ack;
                en = (p >> 2) & 1; lv = (p >> 1) & 1; cg = p & 1;
                exp_ack = (en & lv & cg) << i;
                do_reset();
                enable = en[0]; wire_lvl[i] = lv[0]; wire_chg[i] = cg[0];
                tick();
                chk("R3/R4/R5 ack", ack_out, exp_ack);
                chk("R2 boot", {boot_done, boot_status}, 3);
                chk("R10 first report", plat_state, cg ? 0 : 2);
                wire_lvl[i] = 1'b0; wire_chg[i] = 1'b1;
                tick();
                chk("R6 sticky on deassert", ack_out, exp_ack);
                wire_chg = '0;
                tick();
                chk("R6 sticky", ack_out, exp_ack);
            end
        end

        // Platform reset tracking
        do_reset();
        wire_lvl[3] = 1'b1;
        tick();
        chk("R10 no report", plat_state, 2);
        wire_chg[0] = 1'b1;
        tick();
        chk("R10 first via other wire", plat_state, 1);
        chk("R10 evt", plat_evt, 1);
        wire_chg = '0;
        tick();
        chk("R10 evt one cycle", plat_evt, 0);
        wire_lvl[3] = 1'b0;
        tick();
        chk("R10 level alone", plat_state, 1);
        wire_chg[3] = 1'b1;
        tick();
        chk("R10 change low", plat_state, 0);
        chk("R10 evt low", plat_evt, 1);
        tick();
        chk("R10 repeat report", plat_state, 0);
        chk("R10 no evt on same", plat_evt, 0);
        wire_chg = '0;

        // Update request
        do_reset();
        tick();
        chk("R11 lag", upd_req, 0);
        tick();
        chk("R11 raised", upd_req, 1);
        tick(); tick(); tick();
        chk("R11 held", upd_req, 1);
        upd_ack = 1'b1;
        tick();
        upd_ack = 1'b0;
        chk("R11 accepted", upd_req, 0);
        wire_lvl[1] = 1'b1; wire_chg[1] = 1'b1;
        tick();
        wire_chg = '0;
        chk("R3 host ack", ack_out, 2);
        chk("R11 not yet", upd_req, 0);
        tick();
        chk("R11 ack change", upd_req, 1);
        upd_ack = 1'b1;
        tick();
        upd_ack = 1'b0;
        wire_chg[1] = 1'b1;
        tick();
        wire_chg = '0;
        tick();
        chk("R11 no change no req", upd_req, 0);

        // Power-off entry and hardware reset replay
        do_reset();
        tick();
        g3_entry = 1'b1;
        tick();
        g3_entry = 1'b0;
        chk("R7 cleared", {boot_done, boot_status}, 0);
        wire_lvl[2] = 1'b1; wire_chg[2] = 1'b1;
        tick();
        wire_chg = '0;
        tick(); tick();
        chk("R7 stays clear", {boot_done, boot_status}, 0);
        wire_lvl[0] = 1'b1;
        link_hwrst = 1'b1;
        tick();
        link_hwrst = 1'b0;
        chk("R8 low start", ctrl_rst_n, 0);
        for (int k = 1; k < LOW; k++) begin
            if (k == 1) link_hwrst = 1'b1;
            tick();
            link_hwrst = 1'b0;
            chk("R8 low hold", ctrl_rst_n, 0);
        end
        tick();
        chk("R8 release", ctrl_rst_n, 1);
        chk("R9 not before replay", {boot_done, ack_out[0]}, 0);
        tick();
        chk("R9 boot replay", {boot_done, boot_status}, 3);
        chk("R9 sus replay", ack_out, 5);
        tick();
        chk("R8 retrigger ignored", ctrl_rst_n, 1);

        // Replay with enable low
        do_reset();
        wire_lvl[0] = 1'b1; enable = 1'b0;
        link_hwrst = 1'b1;
        tick();
        link_hwrst = 1'b0;
        for (int k = 0; k < LOW + 2; k++) tick();
        chk("R5 no replay ack", ack_out, 0);
        chk("R9 boot kept", {boot_done, boot_status}, 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule